// File: doc/BRIEF.md
# Dual-Port Byte-Lane RAM with Selectable Read Latency

This block is a true dual-port synchronous RAM with two independent access ports, A and B, sharing one clock. Each word is 18 bits, split into two 9-bit lanes. Each port has its own address, write data, read/write control, per-lane select, output enable, a pair of chip enables of opposite polarity, and a latency mode input. Address, data and control are captured at a rising edge, and the write lands in the array at the following edge. The array is 4096 words deep by default.

A port's read data follows its registered address directly when the mode input is low. When the mode input is high, the read data passes through one extra output register. In place of tristate pads, a lane that is not being driven shows zero and drops its per-lane valid flag. Writes from both ports to the same word in the same cycle leave that word undefined.

Top module: `dpr_dual_ram`

## Requirements
- R1: While rst_ni is low, both ports show rdata zero and valid flags 2'b00.
- R2: A selected cycle with rw high-to-low (rw_i=0) writes the lanes whose select is low. Lane 0 is bits 8:0 and uses lb_ni. Lane 1 is bits 17:9 and uses ub_ni. A lane whose select is high keeps its old contents.
- R3: When pipe_i=0, a read captured at edge N shows its data from just after edge N until edge N+1.
- R4: When pipe_i=1, a read captured at edge N shows its data only after edge N+1. Between edges N and N+1 the port shows the slot captured at edge N-1.
- R5: A lane carries read data, and its valid bit (vld[0] for lane 0, vld[1] for lane 1) is high, only when the port is selected, rw_i=1, oe_ni=0 and that lane's select is low. Otherwise the lane reads zero and its valid bit is low.
- R6: A port is selected only when ce0_ni=0 and ce1_i=1. A deselected cycle writes nothing and drives no data.
- R7: When pipe_i=1, a deselected cycle blanks the output one edge later than it would in flow-through mode. A selected read that follows it needs one full selected cycle before its data is driven.
- R8: Both ports work at the same time on any addresses. A read of a word that the other port writes in the same cycle returns the old contents. A read in the next cycle returns the new contents.
- R9: A write cycle drives no read data: the valid flags are 2'b00 for that slot.
- R10: Every address from 0 to DEPTH-1 reaches a distinct word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Active-low asynchronous reset of the port registers |
| pa_addr_i | input | 12 | Port A word address |
| pa_wdata_i | input | 18 | Port A write data |
| pa_rw_i | input | 1 | Port A: 1 read, 0 write |
| pa_lb_ni | input | 1 | Port A lane 0 select, active low |
| pa_ub_ni | input | 1 | Port A lane 1 select, active low |
| pa_oe_ni | input | 1 | Port A output enable, active low |
| pa_ce0_ni | input | 1 | Port A chip enable, active low |
| pa_ce1_i | input | 1 | Port A chip enable, active high |
| pa_pipe_i | input | 1 | Port A mode: 0 flow-through, 1 registered output |
| pa_rdata_o | output | 18 | Port A read data, zero on undriven lanes |
| pa_vld_o | output | 2 | Port A per-lane valid flags |
| pb_addr_i | input | 12 | Port B word address |
| pb_wdata_i | input | 18 | Port B write data |
| pb_rw_i | input | 1 | Port B: 1 read, 0 write |
| pb_lb_ni | input | 1 | Port B lane 0 select, active low |
| pb_ub_ni | input | 1 | Port B lane 1 select, active low |
| pb_oe_ni | input | 1 | Port B output enable, active low |
| pb_ce0_ni | input | 1 | Port B chip enable, active low |
| pb_ce1_i | input | 1 | Port B chip enable, active high |
| pb_pipe_i | input | 1 | Port B mode: 0 flow-through, 1 registered output |
| pb_rdata_o | output | 18 | Port B read data, zero on undriven lanes |
| pb_vld_o | output | 2 | Port B per-lane valid flags |

## Verification
A corrupted lane-write mask leaves a stale lane, or an overwritten lane, in the array. That fault stays hidden until the word is read back, and then it shows on exactly one 9-bit field. A faulty capture register or enable decode shows at the port's valid flags in the very next cycle in flow-through mode, and one cycle later in registered mode. A mis-ordered write commit shows only in a cross-port read of a word written in the same cycle: the port returns new data where old data was due.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned LANES = 2;

  typedef struct packed {
    logic [LANES-1:0] lane_we;
    logic [LANES-1:0] lane_oe;
  } port_ctl_t;
endpackage

// File: rtl/dpr_port_front.sv
module dpr_port_front
  import dpr_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned W  = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             rw_i,
  input  logic [LANES-1:0] lane_sel_ni,
  input  logic             oe_ni,
  input  logic             ce0_ni,
  input  logic             ce1_i,
  output logic [AW-1:0]    addr_q_o,
  output logic [W-1:0]     wdata_q_o,
  output port_ctl_t        ctl_q_o
);
  logic sel;
  assign sel = ~ce0_ni & ce1_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q_o  <= '0;
      wdata_q_o <= '0;
      ctl_q_o   <= '0;
    end else begin
      addr_q_o        <= addr_i;
      wdata_q_o       <= wdata_i;
      ctl_q_o.lane_we <= {LANES{sel & ~rw_i}} & ~lane_sel_ni;
      ctl_q_o.lane_oe <= {LANES{sel & rw_i & ~oe_ni}} & ~lane_sel_ni;
    end
  end
endmodule

// File: rtl/dpr_array.sv
module dpr_array
  import dpr_pkg::*;
#(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned AW    = 12,
  parameter int unsigned W     = 18
) (
  input  logic             clk_i,
  input  logic [AW-1:0]    a_addr_i,
  input  logic [LANES-1:0] a_we_i,
  input  logic [W-1:0]     a_wdata_i,
  output logic [W-1:0]     a_rdata_o,
  input  logic [AW-1:0]    b_addr_i,
  input  logic [LANES-1:0] b_we_i,
  input  logic [W-1:0]     b_wdata_i,
  output logic [W-1:0]     b_rdata_o
);
  localparam int unsigned LW = W / LANES;

  logic [W-1:0] mem [DEPTH];

  // Port B is applied last; same-word collisions are undefined by contract.
  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (a_we_i[l]) mem[a_addr_i][l*LW +: LW] <= a_wdata_i[l*LW +: LW];
      if (b_we_i[l]) mem[b_addr_i][l*LW +: LW] <= b_wdata_i[l*LW +: LW];
    end
  end

  assign a_rdata_o = mem[a_addr_i];
  assign b_rdata_o = mem[b_addr_i];
endmodule

// File: rtl/dpr_out_stage.sv
module dpr_out_stage
  import dpr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pipe_i,
  input  logic [W-1:0]     rdata_i,
  input  logic [LANES-1:0] lane_oe_i,
  output logic [W-1:0]     rdata_o,
  output logic [LANES-1:0] lane_vld_o
);
  localparam int unsigned LW = W / LANES;

  logic [W-1:0]     gated, gated_q;
  logic [LANES-1:0] oe_q;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      gated[l*LW +: LW] = lane_oe_i[l] ? rdata_i[l*LW +: LW] : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gated_q <= '0;
      oe_q    <= '0;
    end else begin
      gated_q <= gated;
      oe_q    <= lane_oe_i;
    end
  end

  assign rdata_o    = pipe_i ? gated_q : gated;
  assign lane_vld_o = pipe_i ? oe_q : lane_oe_i;
endmodule

// File: rtl/dpr_dual_ram.sv
module dpr_dual_ram
  import dpr_pkg::*;
#(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned WIDTH = 18,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    pa_addr_i,
  input  logic [WIDTH-1:0] pa_wdata_i,
  input  logic             pa_rw_i,
  input  logic             pa_lb_ni,
  input  logic             pa_ub_ni,
  input  logic             pa_oe_ni,
  input  logic             pa_ce0_ni,
  input  logic             pa_ce1_i,
  input  logic             pa_pipe_i,
  output logic [WIDTH-1:0] pa_rdata_o,
  output logic [LANES-1:0] pa_vld_o,
  input  logic [AW-1:0]    pb_addr_i,
  input  logic [WIDTH-1:0] pb_wdata_i,
  input  logic             pb_rw_i,
  input  logic             pb_lb_ni,
  input  logic             pb_ub_ni,
  input  logic             pb_oe_ni,
  input  logic             pb_ce0_ni,
  input  logic             pb_ce1_i,
  input  logic             pb_pipe_i,
  output logic [WIDTH-1:0] pb_rdata_o,
  output logic [LANES-1:0] pb_vld_o
);
  localparam int unsigned NP = 2;

  logic [AW-1:0]    addr_in  [NP];
  logic [WIDTH-1:0] wdata_in [NP];
  logic             rw_in    [NP];
  logic [LANES-1:0] sel_n_in [NP];
  logic             oe_n_in  [NP];
  logic             ce0_n_in [NP];
  logic             ce1_in   [NP];
  logic             pipe_in  [NP];
  logic [AW-1:0]    addr_q   [NP];
  logic [WIDTH-1:0] wdata_q  [NP];
  port_ctl_t        ctl_q    [NP];
  logic [WIDTH-1:0] arr_rd   [NP];
  logic [WIDTH-1:0] rd_out   [NP];
  logic [LANES-1:0] vld_out  [NP];

  assign addr_in[0]  = pa_addr_i;           assign addr_in[1]  = pb_addr_i;
  assign wdata_in[0] = pa_wdata_i;          assign wdata_in[1] = pb_wdata_i;
  assign rw_in[0]    = pa_rw_i;             assign rw_in[1]    = pb_rw_i;
  assign sel_n_in[0] = {pa_ub_ni, pa_lb_ni}; assign sel_n_in[1] = {pb_ub_ni, pb_lb_ni};
  assign oe_n_in[0]  = pa_oe_ni;            assign oe_n_in[1]  = pb_oe_ni;
  assign ce0_n_in[0] = pa_ce0_ni;           assign ce0_n_in[1] = pb_ce0_ni;
  assign ce1_in[0]   = pa_ce1_i;            assign ce1_in[1]   = pb_ce1_i;
  assign pipe_in[0]  = pa_pipe_i;           assign pipe_in[1]  = pb_pipe_i;

  for (genvar p = 0; p < NP; p++) begin : g_port
    dpr_port_front #(.AW(AW), .W(WIDTH)) u_front (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .addr_i      (addr_in[p]),
      .wdata_i     (wdata_in[p]),
      .rw_i        (rw_in[p]),
      .lane_sel_ni (sel_n_in[p]),
      .oe_ni       (oe_n_in[p]),
      .ce0_ni      (ce0_n_in[p]),
      .ce1_i       (ce1_in[p]),
      .addr_q_o    (addr_q[p]),
      .wdata_q_o   (wdata_q[p]),
      .ctl_q_o     (ctl_q[p])
    );

    dpr_out_stage #(.W(WIDTH)) u_out (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pipe_i     (pipe_in[p]),
      .rdata_i    (arr_rd[p]),
      .lane_oe_i  (ctl_q[p].lane_oe),
      .rdata_o    (rd_out[p]),
      .lane_vld_o (vld_out[p])
    );
  end

  dpr_array #(.DEPTH(DEPTH), .AW(AW), .W(WIDTH)) u_array (
    .clk_i     (clk_i),
    .a_addr_i  (addr_q[0]),
    .a_we_i    (ctl_q[0].lane_we),
    .a_wdata_i (wdata_q[0]),
    .a_rdata_o (arr_rd[0]),
    .b_addr_i  (addr_q[1]),
    .b_we_i    (ctl_q[1].lane_we),
    .b_wdata_i (wdata_q[1]),
    .b_rdata_o (arr_rd[1])
  );

  assign pa_rdata_o = rd_out[0];
  assign pa_vld_o   = vld_out[0];
  assign pb_rdata_o = rd_out[1];
  assign pb_vld_o   = vld_out[1];
endmodule

// File: rtl/dpr_dual_ram_chk.sv
module dpr_dual_ram_chk #(
  parameter int unsigned WIDTH = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pa_rw_i,
  input logic             pa_lb_ni,
  input logic             pa_ub_ni,
  input logic             pa_oe_ni,
  input logic             pa_ce0_ni,
  input logic             pa_ce1_i,
  input logic             pa_pipe_i,
  input logic [WIDTH-1:0] pa_rdata_o,
  input logic [1:0]       pa_vld_o,
  input logic             pb_oe_ni,
  input logic             pb_ce0_ni,
  input logic             pb_ce1_i,
  input logic             pb_pipe_i,
  input logic [WIDTH-1:0] pb_rdata_o,
  input logic [1:0]       pb_vld_o
);
  localparam int unsigned LW = WIDTH / 2;

  logic a_sel, b_sel;
  assign a_sel = ~pa_ce0_ni & pa_ce1_i;
  assign b_sel = ~pb_ce0_ni & pb_ce1_i;

  assert_idle_lane_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pa_vld_o[0] || pa_rdata_o[LW-1:0] == '0) && (pa_vld_o[1] || pa_rdata_o[WIDTH-1:LW] == '0) &&
    (pb_vld_o[0] || pb_rdata_o[LW-1:0] == '0) && (pb_vld_o[1] || pb_rdata_o[WIDTH-1:LW] == '0));

  assert_desel_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pa_pipe_i && !a_sel) |=> (pa_pipe_i || pa_vld_o == 2'b00));

  assert_write_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pa_pipe_i && a_sel && !pa_rw_i) |=> (pa_pipe_i || pa_vld_o == 2'b00));

  assert_oe_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pa_pipe_i && pa_oe_ni) |=> (pa_pipe_i || pa_vld_o == 2'b00));

  assert_lane_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pa_pipe_i && (pa_lb_ni || pa_ub_ni)) |=>
      (pa_pipe_i || (!(pa_lb_ni_q && pa_vld_o[0]) && !(pa_ub_ni_q && pa_vld_o[1]))));

  assert_pipe_desel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pb_pipe_i && !b_sel) |=> ##1 (!pb_pipe_i || pb_vld_o == 2'b00));

  assert_pipe_oe_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pb_pipe_i && b_sel && pb_oe_ni) |=> ##1 (!pb_pipe_i || pb_vld_o == 2'b00));

  logic pa_lb_ni_q, pa_ub_ni_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_lb_ni_q <= 1'b0;
      pa_ub_ni_q <= 1'b0;
    end else begin
      pa_lb_ni_q <= pa_lb_ni;
      pa_ub_ni_q <= pa_ub_ni;
    end
  end
endmodule

bind dpr_dual_ram dpr_dual_ram_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pa_rw_i    (pa_rw_i),
  .pa_lb_ni   (pa_lb_ni),
  .pa_ub_ni   (pa_ub_ni),
  .pa_oe_ni   (pa_oe_ni),
  .pa_ce0_ni  (pa_ce0_ni),
  .pa_ce1_i   (pa_ce1_i),
  .pa_pipe_i  (pa_pipe_i),
  .pa_rdata_o (pa_rdata_o),
  .pa_vld_o   (pa_vld_o),
  .pb_oe_ni   (pb_oe_ni),
  .pb_ce0_ni  (pb_ce0_ni),
  .pb_ce1_i   (pb_ce1_i),
  .pb_pipe_i  (pb_pipe_i),
  .pb_rdata_o (pb_rdata_o),
  .pb_vld_o   (pb_vld_o)
);

// File: tb/dpr_dual_ram_test.sv
module dpr_dual_ram_test;
  localparam int unsigned DEPTH = 4096;
  localparam int unsigned AW    = 12;
  localparam int unsigned W     = 18;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [W-1:0]  data;
    logic [1:0]    sel_n; // {ub_n, lb_n}
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{12'h000, 18'h2A5A5, 2'b00},
    '{12'hFFF, 18'h15A5A, 2'b00},
    '{12'h123, 18'h0FFFF, 2'b00},
    '{12'h000, 18'h3FE00, 2'b01},
    '{12'hFFF, 18'h001FF, 2'b10},
    '{12'h123, 18'h3FFFF, 2'b11},
    '{12'h800, 18'h1C3C3, 2'b00},
    '{12'h800, 18'h00000, 2'b01}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] pa_addr, pb_addr;
  logic [W-1:0]  pa_wdata, pb_wdata, pa_rdata, pb_rdata;
  logic pa_rw, pa_lb_n, pa_ub_n, pa_oe_n, pa_ce0_n, pa_ce1, pa_pipe;
  logic pb_rw, pb_lb_n, pb_ub_n, pb_oe_n, pb_ce0_n, pb_ce1, pb_pipe;
  logic [1:0] pa_vld, pb_vld;

  logic [W-1:0] model [DEPTH];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dpr_dual_ram uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .pa_addr_i(pa_addr), .pa_wdata_i(pa_wdata), .pa_rw_i(pa_rw), .pa_lb_ni(pa_lb_n),
    .pa_ub_ni(pa_ub_n), .pa_oe_ni(pa_oe_n), .pa_ce0_ni(pa_ce0_n), .pa_ce1_i(pa_ce1),
    .pa_pipe_i(pa_pipe), .pa_rdata_o(pa_rdata), .pa_vld_o(pa_vld),
    .pb_addr_i(pb_addr), .pb_wdata_i(pb_wdata), .pb_rw_i(pb_rw), .pb_lb_ni(pb_lb_n),
    .pb_ub_ni(pb_ub_n), .pb_oe_ni(pb_oe_n), .pb_ce0_ni(pb_ce0_n), .pb_ce1_i(pb_ce1),
    .pb_pipe_i(pb_pipe), .pb_rdata_o(pb_rdata), .pb_vld_o(pb_vld)
  );

  function automatic logic [W-1:0] merge(logic [W-1:0] old, logic [W-1:0] nw, logic [1:0] sel_n);
    logic [W-1:0] r = old;
    if (!sel_n[0]) r[8:0]  = nw[8:0];
    if (!sel_n[1]) r[17:9] = nw[17:9];
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp,
                     logic [1:0] gv, logic [1:0] ev);
    n_chk++;
    if (got !== exp || gv !== ev) begin
      n_bad++;
      $display("FAIL %s: data %h vld %b, expected data %h vld %b", req, got, gv, exp, ev);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic idle_a();
    pa_ce0_n = 1'b1; pa_ce1 = 1'b1; pa_rw = 1'b1; pa_lb_n = 1'b0; pa_ub_n = 1'b0; pa_oe_n = 1'b0;
  endtask
  task automatic idle_b();
    pb_ce0_n = 1'b1; pb_ce1 = 1'b1; pb_rw = 1'b1; pb_lb_n = 1'b0; pb_ub_n = 1'b0; pb_oe_n = 1'b0;
  endtask

  task automatic wr_a(logic [AW-1:0] a, logic [W-1:0] d, logic [1:0] sel_n);
    pa_ce0_n = 1'b0; pa_ce1 = 1'b1; pa_rw = 1'b0; pa_addr = a; pa_wdata = d;
    pa_lb_n = sel_n[0]; pa_ub_n = sel_n[1]; pa_oe_n = 1'b0;
    model[a] = merge(model[a], d, sel_n);
  endtask
  task automatic wr_b(logic [AW-1:0] a, logic [W-1:0] d, logic [1:0] sel_n);
    pb_ce0_n = 1'b0; pb_ce1 = 1'b1; pb_rw = 1'b0; pb_addr = a; pb_wdata = d;
    pb_lb_n = sel_n[0]; pb_ub_n = sel_n[1]; pb_oe_n = 1'b0;
    model[a] = merge(model[a], d, sel_n);
  endtask
  task automatic rd_a(logic [AW-1:0] a, logic [1:0] sel_n, logic oe_n);
    pa_ce0_n = 1'b0; pa_ce1 = 1'b1; pa_rw = 1'b1; pa_addr = a;
    pa_lb_n = sel_n[0]; pa_ub_n = sel_n[1]; pa_oe_n = oe_n;
  endtask
  task automatic rd_b(logic [AW-1:0] a);
    pb_ce0_n = 1'b0; pb_ce1 = 1'b1; pb_rw = 1'b1; pb_addr = a;
    pb_lb_n = 1'b0; pb_ub_n = 1'b0; pb_oe_n = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    pa_addr = '0; pb_addr = '0; pa_wdata = '0; pb_wdata = '0;
    pa_pipe = 1'b0; pb_pipe = 1'b1;
    idle_a(); idle_b();
    step(); step();
    chk("R1 port A in reset", pa_rdata, '0, pa_vld, 2'b00);
    chk("R1 port B in reset", pb_rdata, '0, pb_vld, 2'b00);
    rst_ni = 1'b1;
    step();

    // Table walk: write on A, read back on A (flow) and B (registered)
    for (int i = 0; i < 8; i++) begin
      wr_a(VECS[i].addr, VECS[i].data, VECS[i].sel_n); idle_b();
      step();
      chk("R9 write slot shows nothing", pa_rdata, '0, pa_vld, 2'b00);
      rd_a(VECS[i].addr, 2'b00, 1'b0); rd_b(VECS[i].addr);
      step();
      chk("R2/R3/R10 flow read A", pa_rdata, model[VECS[i].addr], pa_vld, 2'b11);
      chk("R4 registered B not yet", pb_rdata, '0, pb_vld, 2'b00);
      idle_a(); idle_b();
      step();
      chk("R2/R4/R10 registered read B", pb_rdata, model[VECS[i].addr], pb_vld, 2'b11);
    end

    // R5: output enable and lane selects gate the read
    rd_a(12'h000, 2'b00, 1'b1); step();
    chk("R5 oe high", pa_rdata, '0, pa_vld, 2'b00);
    rd_a(12'h000, 2'b10, 1'b0); step();
    chk("R5 lane 0 only", pa_rdata, {9'h0, model[0][8:0]}, pa_vld, 2'b01);
    rd_a(12'h000, 2'b01, 1'b0); step();
    chk("R5 lane 1 only", pa_rdata, {model[0][17:9], 9'h0}, pa_vld, 2'b10);

    // R6: both chip enables must be active
    wr_a(12'h055, 18'h12345, 2'b00); step();
    pa_ce0_n = 1'b0; pa_ce1 = 1'b0; pa_rw = 1'b0; pa_wdata = 18'h00000; step();
    pa_ce0_n = 1'b1; pa_ce1 = 1'b1; step();
    pa_ce0_n = 1'b1; pa_ce1 = 1'b0; pa_rw = 1'b1; step();
    chk("R6 deselected read", pa_rdata, '0, pa_vld, 2'b00);
    rd_a(12'h055, 2'b00, 1'b0); step();
    chk("R6 deselected writes ignored", pa_rdata, 18'h12345, pa_vld, 2'b11);
    idle_a();

    // R7: registered mode after a deselect
    idle_b(); step();
    rd_b(12'h055); step();
    chk("R7 first selected cycle blank", pb_rdata, '0, pb_vld, 2'b00);
    rd_b(12'h000); step();
    chk("R7 data after one selected cycle", pb_rdata, 18'h12345, pb_vld, 2'b11);
    idle_b(); step();
    chk("R4 back-to-back registered read", pb_rdata, model[0], pb_vld, 2'b11);
    step();
    chk("R7 deselect blanks registered port", pb_rdata, '0, pb_vld, 2'b00);

    // R8: cross-port read of a word written in the same cycle
    pb_pipe = 1'b0;
    wr_a(12'h055, 18'h2AAAA, 2'b00); rd_b(12'h055); step();
    chk("R8 same-cycle read sees old", pb_rdata, 18'h12345, pb_vld, 2'b11);
    idle_a(); rd_b(12'h055); step();
    chk("R8 next-cycle read sees new", pb_rdata, 18'h2AAAA, pb_vld, 2'b11);
    wr_a(12'h060, 18'h11111, 2'b00); wr_b(12'h061, 18'h22222, 2'b00); step();
    rd_a(12'h061, 2'b00, 1'b0); rd_b(12'h060); step();
    chk("R8 A reads B's word", pa_rdata, 18'h22222, pa_vld, 2'b11);
    chk("R8 B reads A's word", pb_rdata, 18'h11111, pb_vld, 2'b11);

    // R10: top address is distinct from address 0
    idle_a(); wr_b(12'hFFF, 18'h3FFFF, 2'b00); step();
    rd_a(12'h000, 2'b00, 1'b0); idle_b(); step();
    chk("R10 word 0 untouched", pa_rdata, model[0], pa_vld, 2'b11);
    rd_a(12'hFFF, 2'b00, 1'b0); step();
    chk("R10 top word", pa_rdata, 18'h3FFFF, pa_vld, 2'b11);
    idle_a(); step();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule